// File: doc/BRIEF.md
# Gray-Code Reciprocal Frequency Counter

This block measures the rate of an external signal by letting that signal clock its own counter. The counter advances in Gray code, so exactly one bit changes per rising edge of the measured signal. A two-flop synchronizer brings the count into the system-clock domain. Because only one bit can be in motion, a sample taken during a change is off by at most one count. The sampled value is decoded to binary after the synchronizer.

A gate timer runs on the system clock. Its length is chosen from five cycle counts by a 3-bit select, and these set the trade between update rate and resolution. At the end of every gate the block subtracts the previous decoded snapshot from the current one, modulo the counter width. The result is the number of rising edges of the measured signal in that gate, and it is published with a one-cycle strobe. With a 1 MHz system clock, the default lengths give windows from 0.1 s to 10 s.

Top module: `freq_gray_meter`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o` is 0 and `count_o` is 0 until the first result.
- R2: Each result equals the number of rising edges of `sig_i` in one gate, when the signal is steady and the gate length is a multiple of its period.
- R3: Select codes 0, 1, 2, 3 and 4 choose gate lengths GATE_LEN0 to GATE_LEN4 system-clock cycles respectively. The defaults are 100k, 250k, 500k, 1M and 10M.
- R4: Select codes 5, 6 and 7 behave as code 3. Moving between code 3 and any of them does not restart the gate.
- R5: `valid_o` is high for exactly one cycle per completed gate. `count_o` changes only in a cycle where `valid_o` is high and holds otherwise.
- R6: When the resolved gate length changes, the timer restarts on the edge that samples the new code. The first complete gate after that yields no result. The first `valid_o` appears on the 2×L-th edge after that sampling edge, where L is the new length.
- R7: The subtraction is taken modulo 2^CNT_W, so a result is correct when the edge counter wraps inside a gate.
- R8: The counter clocked by `sig_i` changes at most one bit per rising edge of `sig_i`.
- R9: A length change sampled on the very edge where a gate would end takes precedence. No result is produced on that edge, and the R6 timing applies from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| sig_i | input | 1 | Signal being measured; clocks the Gray counter |
| gate_sel_i | input | 3 | Gate length code |
| count_o | output | CNT_W | Rising edges of `sig_i` counted in the last gate |
| valid_o | output | 1 | One-cycle strobe marking a new `count_o` |

## Verification
The end of a gate and a change of gate length can land on the same system-clock edge. The bench waits for a result, then counts exactly one gate length less one cycle. It then drives a new code so that the code is sampled on the edge where the next gate would close. No strobe may appear there, and the next strobe must arrive exactly twice the new length later. The bench also changes the code to an alias of the current length part-way through a gate, and requires the strobe spacing to stay unchanged.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_MAX     = 3'd4;
  localparam logic [SEL_W-1:0] SEL_DEFAULT = 3'd3;

  // map undefined codes onto the default length
  function automatic logic [SEL_W-1:0] fm_resolve(input logic [SEL_W-1:0] code);
    return (code > SEL_MAX) ? SEL_DEFAULT : code;
  endfunction
endpackage

// File: rtl/fm_gray_counter.sv
module fm_gray_counter #(
  parameter int unsigned W = 16
) (
  input  logic         sig_i,
  input  logic         rst_ni,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_q;
  logic [W-1:0] bin_nx;

  assign bin_nx = bin_q + W'(1);

  always_ff @(posedge sig_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/fm_gray_sync.sv
module fm_gray_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  // decode after the second flop: bit i is the parity of bits i and above
  for (genvar i = 0; i < W; i++) begin : g_dec
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer
  import freq_meter_pkg::*;
#(
  parameter int unsigned GATE_LEN0 = 100000,
  parameter int unsigned GATE_LEN1 = 250000,
  parameter int unsigned GATE_LEN2 = 500000,
  parameter int unsigned GATE_LEN3 = 1000000,
  parameter int unsigned GATE_LEN4 = 10000000,
  parameter int unsigned TW        = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic             restart_o
);
  logic [SEL_W-1:0] idx_q, idx_nx;
  logic [TW-1:0]    cnt_q, len_cur;

  assign idx_nx = fm_resolve(sel_i);

  always_comb begin
    unique case (idx_q)
      3'd0:    len_cur = TW'(GATE_LEN0);
      3'd1:    len_cur = TW'(GATE_LEN1);
      3'd2:    len_cur = TW'(GATE_LEN2);
      3'd4:    len_cur = TW'(GATE_LEN4);
      default: len_cur = TW'(GATE_LEN3);
    endcase
  end

  // a length change wins over a gate end on the same edge
  assign restart_o = (idx_nx != idx_q);
  assign tick_o    = !restart_o && (cnt_q == len_cur - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= SEL_DEFAULT;
      cnt_q <= '0;
    end else if (restart_o) begin
      idx_q <= idx_nx;
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/freq_gray_meter.sv
module freq_gray_meter
  import freq_meter_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GATE_LEN0 = 100000,
  parameter int unsigned GATE_LEN1 = 250000,
  parameter int unsigned GATE_LEN2 = 500000,
  parameter int unsigned GATE_LEN3 = 1000000,
  parameter int unsigned GATE_LEN4 = 10000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  input  logic [2:0]       gate_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  localparam int unsigned MAX_A   = (GATE_LEN0 > GATE_LEN1) ? GATE_LEN0 : GATE_LEN1;
  localparam int unsigned MAX_B   = (GATE_LEN2 > GATE_LEN3) ? GATE_LEN2 : GATE_LEN3;
  localparam int unsigned MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_LEN = (MAX_C > GATE_LEN4) ? MAX_C : GATE_LEN4;
  localparam int unsigned TW      = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] gray_w, bin_w, snap_q;
  logic             tick_w, restart_w, armed_q;

  fm_gray_counter #(.W(CNT_W)) u_cnt (
    .sig_i  (sig_i),
    .rst_ni (rst_ni),
    .gray_o (gray_w)
  );

  fm_gray_sync #(.W(CNT_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gray_i (gray_w),
    .bin_o  (bin_w)
  );

  fm_gate_timer #(
    .GATE_LEN0 (GATE_LEN0),
    .GATE_LEN1 (GATE_LEN1),
    .GATE_LEN2 (GATE_LEN2),
    .GATE_LEN3 (GATE_LEN3),
    .GATE_LEN4 (GATE_LEN4),
    .TW        (TW)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (gate_sel_i),
    .tick_o    (tick_w),
    .restart_o (restart_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      armed_q <= 1'b0;
      count_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (restart_w) begin
        armed_q <= 1'b0;
      end else if (tick_w) begin
        snap_q  <= bin_w;
        armed_q <= 1'b1;
        if (armed_q) begin
          count_o <= bin_w - snap_q; // modulo 2^CNT_W
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker
  import freq_meter_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sig_i,
  input logic [2:0]       gate_sel_i,
  input logic [CNT_W-1:0] count_o,
  input logic             valid_o,
  input logic [CNT_W-1:0] gray_w
);
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r5_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_o) |-> valid_o);

  a_r6_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fm_resolve(gate_sel_i) != fm_resolve($past(gate_sel_i))) |=> !valid_o);

  a_r8_gray_step: assert property (@(posedge sig_i) disable iff (!rst_ni)
    $countones(gray_w ^ $past(gray_w)) <= 1);
endmodule

bind freq_gray_meter fm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sig_i      (sig_i),
  .gate_sel_i (gate_sel_i),
  .count_o    (count_o),
  .valid_o    (valid_o),
  .gray_w     (gray_w)
);

// File: tb/freq_gray_meter_tb_top.sv
module freq_gray_meter_tb_top;
  localparam int CW = 10;
  localparam int L0 = 20, L1 = 50, L2 = 100, L3 = 200, L4 = 2000;

  logic          clk = 1'b0, rst_n = 1'b0, sig = 1'b0;
  logic [2:0]    sel = 3'd3;
  logic [CW-1:0] cnt;
  logic          vld;
  int            checks = 0, errors = 0;
  int            sig_per = 2, ph = 0;

  freq_gray_meter #(
    .CNT_W(CW), .GATE_LEN0(L0), .GATE_LEN1(L1), .GATE_LEN2(L2),
    .GATE_LEN3(L3), .GATE_LEN4(L4)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .gate_sel_i(sel),
    .count_o(cnt), .valid_o(vld)
  );

  always #2 clk = ~clk;

  // measured signal: one rising edge every sig_per system cycles, changed at negedge
  initial forever begin
    @(negedge clk);
    ph  = (ph + 1 >= sig_per) ? 0 : ph + 1;
    sig = (ph < sig_per / 2);
  end

  function automatic int len_of(input int code);
    case (code)
      0: return L0;
      1: return L1;
      2: return L2;
      4: return L4;
      default: return L3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!vld && n < 20000);
  endtask

  task automatic restart_to(input int code);
    int n;
    @(negedge clk);
    sel = 3'(code);
    wait_valid(n);
    chk(n == 2 * len_of(code) + 1, "R6 first result delay", n, 2 * len_of(code) + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [CW-1:0] held;
    int pers[3] = '{2, 5, 10};

    repeat (3) @(negedge clk);
    chk(cnt == 0 && vld == 0, "R1 reset outputs", int'(cnt) + int'(vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnt == 0 && vld == 0, "R1 after release", int'(cnt) + int'(vld), 0);

    restart_to(0);

    // sweep every code against several signal periods
    for (int code = 0; code < 8; code++) begin
      for (int p = 0; p < 3; p++) begin
        int exp;
        sig_per = pers[p];
        @(negedge clk);
        sel = 3'(code);
        exp = len_of(code) / pers[p];
        wait_valid(n);
        for (int k = 0; k < 2; k++) begin
          wait_valid(n);
          if (code > 4)
            chk(int'(cnt) == exp, "R2 R4 alias count", int'(cnt), exp);
          else if (code == 4)
            chk(int'(cnt) == exp, "R2 R3 R7 long gate across wrap", int'(cnt), exp);
          else
            chk(int'(cnt) == exp, "R2 R3 count", int'(cnt), exp);
          held = cnt;
          @(negedge clk);
          chk(!vld && cnt == held, "R5 strobe width and hold", int'(vld), 0);
        end
      end
    end

    // alias switch mid-gate must not disturb strobe spacing
    sig_per = 5;
    wait_valid(n);
    repeat (50) @(negedge clk);
    sel = 3'd3;
    wait_valid(n);
    chk(n == L3 - 50, "R4 no restart on alias", n, L3 - 50);

    // length change sampled on the closing edge of a gate
    wait_valid(n);
    repeat (L3 - 1) @(negedge clk);
    sel = 3'd1;
    wait_valid(n);
    chk(n == 2 * L1 + 1, "R9 R6 change on gate end", n, 2 * L1 + 1);

    restart_to(2);
    wait_valid(n);
    chk(int'(cnt) == L2 / 5, "R2 after restart", int'(cnt), L2 / 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule